// File: doc/BRIEF.md
# Big-Endian Narrow Load/Store Aligner

This unit sits between the register datapath and a word-wide, byte-addressed data memory whose byte order is big-endian: the lowest byte address within a word holds the most significant byte. For a store it takes the rightmost byte, halfword or full word of the register value, places it in the addressed lane(s) and raises one write enable per byte lane. For a load it picks the addressed byte or halfword out of the word the memory returns and widens it to the full data width, either by copying its sign bit or by filling with zeros.

The memory is assumed to be synchronous. It samples the request on one clock edge and returns the read word during the following cycle. The aligner therefore holds the load's size, offset and signedness in a register for one cycle, and shapes the returned word with those held values. Store data and byte enables are formed combinationally in the request cycle. Any access whose address does not suit its size is flagged at once. A flagged access never writes and never yields a load result.

Top module: `be_lsu_aligner`

## Requirements
- R1: `req_size` encodes 00 = byte, 01 = halfword, 10 = word. The code 11 is reserved and is always treated as a misaligned access.
- R2: In the request cycle, `misalign` is high exactly when `req_valid` is high and one of these holds: a halfword with `req_off[0]`=1, a word with `req_off`≠0, or the reserved size. A flagged access drives `wr_be` to 0000 and `wr_data` to zero.
- R3: An aligned store drives these byte enables. A byte store raises only bit 3−`req_off`: bit 3 is offset 0, which is bits 31..24, and bit 0 is offset 3, which is bits 7..0. A halfword store gives 1100 at offset 0 and 0011 at offset 2. A word store gives 1111.
- R4: An aligned store drives these write data. A byte store puts `st_data[7:0]` in all four lanes. A halfword store puts `st_data[15:0]` in both halves. A word store passes `st_data` unchanged. When there is no aligned store, `wr_data` is zero.
- R5: A load request, aligned or not, never raises any `wr_be` bit.
- R6: `ld_valid` is high in the cycle after an aligned load request and low in every other cycle. `ld_data` is zero whenever `ld_valid` is low.
- R7: Load lanes are selected big-endian. A byte at offset k is `rd_word[31−8k:24−8k]`. A halfword at offset 0 is bits 31..16 and at offset 2 is bits 15..0. A word load returns `rd_word` unchanged.
- R8: A signed byte or halfword load (`req_signed`=1) copies the item's top bit into every upper bit of `ld_data`.
- R9: An unsigned byte or halfword load fills the upper bits of `ld_data` with zeros.
- R10: While `rst_n` is low, and after it is released with no request, `ld_valid` and `ld_data` are zero.
- R11: The result uses the size, offset and signedness from the request cycle. Values on `req_size`, `req_off` and `req_signed` during the data-return cycle have no effect on `ld_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Transfer size code (R1) |
| req_signed | input | 1 | Sign-extend a narrow load |
| req_off | input | 2 | Byte offset within the word (address low bits) |
| st_data | input | 32 | Register value to store |
| rd_word | input | 32 | Word returned by memory, one cycle after the request |
| wr_data | output | 32 | Lane-placed store data |
| wr_be | output | 4 | Per-byte write enables, bit 3 = offset 0 |
| misalign | output | 1 | Current request is misaligned or of reserved size |
| ld_valid | output | 1 | `ld_data` holds a load result |
| ld_data | output | 32 | Extended load result |

## Verification
The store side has no state. A wrong lane map or a wrong fault decode therefore appears on `wr_be`, `wr_data` or `misalign` in the same cycle as the request. The only state is the held load attributes, and an error there appears one cycle later: the wrong lane, the wrong extension, or a `ld_valid` pulse that is missing or extra. The bench sweeps every size code, offset, signedness and direction, and then scrambles the request inputs in the return cycle so that stale attributes are caught.

// File: rtl/lsa_pkg.sv
// Shared types for the big-endian load/store aligner.
// Assumes a 2-bit size code; the reserved code is always treated as a fault.
package lsa_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;
endpackage

// File: rtl/lsa_align_chk.sv
// Alignment checker: decides whether an offset suits the transfer size.
// Assumes a power-of-two lane count; a halfword needs an even offset and a
// full word needs offset zero. The reserved size always faults.
module lsa_align_chk
    import lsa_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  xfer_size_e       size,
    input  logic [OFF_W-1:0] off,
    output logic             fault
);
    // Purpose: combinational fault decode per size.
    always_comb begin
        unique case (size)
            SZ_BYTE: fault = 1'b0;
            SZ_HALF: fault = off[0];
            SZ_WORD: fault = |off;
            default: fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsa_store_lane.sv
// Store lane placer: puts the rightmost byte/halfword (or the whole word)
// of the register into the lanes and raises per-lane write enables.
// Lane g holds byte offset g, i.e. bits DATA_W-1-8g down to DATA_W-8-8g
// (big-endian); its enable is bit LANES-1-g. Narrow data is replicated.
module lsa_store_lane
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              en,
    input  xfer_size_e        size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] st_data,
    output logic [DATA_W-1:0] wr_data,
    output logic [LANES-1:0]  wr_be
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HI = DATA_W - 1 - 8 * g;
        logic       hit;
        logic [7:0] byte_v;

        // Purpose: decide whether this lane is written by the current store.
        always_comb begin
            unique case (size)
                SZ_BYTE: hit = (off == OFF_W'(g));
                SZ_HALF: hit = (off[OFF_W-1:1] == (OFF_W-1)'(g / 2));
                SZ_WORD: hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end

        // Purpose: choose the register byte this lane carries.
        always_comb begin
            unique case (size)
                SZ_BYTE: byte_v = st_data[7:0];
                SZ_HALF: byte_v = (g % 2 == 0) ? st_data[15:8] : st_data[7:0];
                default: byte_v = st_data[HI -: 8];
            endcase
        end

        assign wr_data[HI -: 8]    = en ? byte_v : 8'h00;
        assign wr_be[LANES-1-g]    = en & hit;
    end
endmodule

// File: rtl/lsa_load_extract.sv
// Load extractor: selects the addressed byte or halfword from the returned
// word using big-endian lane order and widens it by sign or zero fill.
// Assumes a power-of-two lane count so that LANES-1-off equals ~off.
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              active,
    input  xfer_size_e        size,
    input  logic [OFF_W-1:0]  off,
    input  logic              sext,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] ld_data
);
    logic [7:0]  byte_v;
    logic [15:0] half_v;
    logic [OFF_W-1:0] inv_off;
    logic [OFF_W-2:0] inv_half;

    assign inv_off  = ~off;
    assign inv_half = ~off[OFF_W-1:1];

    // Purpose: shift the addressed item down to the low end of the word.
    always_comb begin
        byte_v = 8'(rd_word >> {inv_off, 3'b000});
        half_v = 16'(rd_word >> {inv_half, 4'b0000});
    end

    // Purpose: widen the selected item and gate by result validity.
    always_comb begin
        if (!active) begin
            ld_data = '0;
        end else begin
            unique case (size)
                SZ_BYTE: ld_data = {{(DATA_W-8){sext & byte_v[7]}}, byte_v};
                SZ_HALF: ld_data = {{(DATA_W-16){sext & half_v[15]}}, half_v};
                default: ld_data = rd_word;
            endcase
        end
    end
endmodule

// File: rtl/be_lsu_aligner.sv
// Top of the big-endian narrow load/store aligner.
// Assumes a synchronous memory: the request is taken on one edge and the
// read word arrives in the next cycle. Store outputs are combinational in
// the request cycle; load attributes are held one cycle for the return.
module be_lsu_aligner
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] wr_data,
    output logic [LANES-1:0]  wr_be,
    output logic              misalign,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);
    xfer_size_e       size_in;
    logic             fault;
    logic             store_ok;
    logic             load_ok;

    xfer_size_e       size_q;
    logic [OFF_W-1:0] off_q;
    logic             sext_q;
    logic             pend_q;

    assign size_in  = xfer_size_e'(req_size);
    assign misalign = req_valid & fault;
    assign store_ok = req_valid &  req_store & ~fault;
    assign load_ok  = req_valid & ~req_store & ~fault;

    lsa_align_chk #(.OFF_W(OFF_W)) u_align (
        .size  (size_in),
        .off   (req_off),
        .fault (fault)
    );

    lsa_store_lane #(.DATA_W(DATA_W)) u_store (
        .en      (store_ok),
        .size    (size_in),
        .off     (req_off),
        .st_data (st_data),
        .wr_data (wr_data),
        .wr_be   (wr_be)
    );

    // Purpose: hold the load attributes until the memory word returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            size_q <= SZ_WORD;
            off_q  <= '0;
            sext_q <= 1'b0;
        end else begin
            pend_q <= load_ok;
            if (load_ok) begin
                size_q <= size_in;
                off_q  <= req_off;
                sext_q <= req_signed;
            end
        end
    end

    lsa_load_extract #(.DATA_W(DATA_W)) u_load (
        .active  (pend_q),
        .size    (size_q),
        .off     (off_q),
        .sext    (sext_q),
        .rd_word (rd_word),
        .ld_data (ld_data)
    );

    assign ld_valid = pend_q;
endmodule

// File: rtl/be_lsu_aligner_chk.sv
// Port-level property checker for be_lsu_aligner, attached by bind.
// Assumes the default 32-bit width for the extension checks.
module be_lsu_aligner_chk #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [1:0]        req_size,
    input logic              req_signed,
    input logic [OFF_W-1:0]  req_off,
    input logic [DATA_W-1:0] wr_data,
    input logic [LANES-1:0]  wr_be,
    input logic              misalign,
    input logic              ld_valid,
    input logic [DATA_W-1:0] ld_data
);
    p_fault_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (wr_be == '0 && wr_data == '0));

    p_rsvd_faults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b11) |-> misalign);

    p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'b00) |-> $countones(wr_be) == 1);

    p_load_no_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store) |-> wr_be == '0);

    p_load_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && !misalign) |=> ld_valid);

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_store && !misalign) |=> !ld_valid);

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> ld_data == '0);

    p_sign_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && $past(req_size) == 2'b00 && $past(req_signed))
        |-> ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}});

    p_zero_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && $past(req_size) == 2'b01 && !$past(req_signed))
        |-> ld_data[DATA_W-1:16] == '0);
endmodule

bind be_lsu_aligner be_lsu_aligner_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_size   (req_size),
    .req_signed (req_signed),
    .req_off    (req_off),
    .wr_data    (wr_data),
    .wr_be      (wr_be),
    .misalign   (misalign),
    .ld_valid   (ld_valid),
    .ld_data    (ld_data)
);

// File: tb/tb_be_lsu_aligner.sv
`timescale 1ns/1ps
// Exhaustive sweep of size code, offset, signedness and direction with
// expected values computed arithmetically from the requirements.
module tb_be_lsu_aligner;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_store, req_signed;
    logic [1:0]  req_size, req_off;
    logic [31:0] st_data, rd_word;
    logic [31:0] wr_data, ld_data;
    logic [3:0]  wr_be;
    logic        misalign, ld_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    be_lsu_aligner dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_signed(req_signed), .req_off(req_off),
        .st_data(st_data), .rd_word(rd_word), .wr_data(wr_data), .wr_be(wr_be),
        .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_bad(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'b11) return 1'b1;          // R1 reserved code
        if (sz == 2'b01) return off[0];
        if (sz == 2'b10) return off != 2'b00;
        return 1'b0;
    endfunction

    initial begin
        logic [31:0] st_pat [2];
        logic [31:0] rd_pat [2];
        st_pat[0] = 32'hCAFE_F00D; st_pat[1] = 32'h1357_9B2F;
        rd_pat[0] = 32'h9A3C_E507; rd_pat[1] = 32'h7FFE_8001;
        rst_n = 1'b0; req_valid = 0; req_store = 0; req_signed = 0;
        req_size = 0; req_off = 0; st_data = 0; rd_word = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        #1;
        chk("R10 ld_valid in reset", {31'b0, ld_valid}, 32'd0);
        chk("R10 ld_data in reset", ld_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R10 ld_valid after reset", {31'b0, ld_valid}, 32'd0);
        chk("R10 ld_data after reset", ld_data, 32'd0);

        for (int p = 0; p < 2; p++)
        for (int dir = 0; dir < 2; dir++)
        for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
        for (int sg = 0; sg < 2; sg++) begin
            logic [1:0]  s2, o2;
            bit          bad;
            logic [3:0]  e_be;
            logic [31:0] e_wd, e_ld, w;
            logic [7:0]  b;
            logic [15:0] h;
            string       ltag;
            @(negedge clk);
            s2 = 2'(sz); o2 = 2'(off);
            bad = is_bad(s2, o2);
            req_valid = 1; req_store = dir[0]; req_size = s2; req_off = o2;
            req_signed = sg[0]; st_data = st_pat[p]; rd_word = 32'h0;
            // expected store side
            e_be = 4'h0; e_wd = 32'h0;
            if (dir == 1 && !bad) begin
                if (sz == 0) begin e_be = 4'(8 >> off); e_wd = {4{st_pat[p][7:0]}}; end
                else if (sz == 1) begin e_be = (off == 0) ? 4'hC : 4'h3; e_wd = {2{st_pat[p][15:0]}}; end
                else begin e_be = 4'hF; e_wd = st_pat[p]; end
            end
            #1;
            chk("R2 misalign", {31'b0, misalign}, {31'b0, bad});
            chk(dir == 1 ? "R3 wr_be" : "R5 wr_be on load", {28'b0, wr_be}, {28'b0, e_be});
            chk("R4 wr_data", wr_data, e_wd);
            @(negedge clk);
            // return cycle: scramble request inputs (R11) and present the word
            req_valid = 0; req_size = ~s2; req_off = ~o2; req_signed = ~sg[0];
            rd_word = rd_pat[p];
            w = rd_pat[p];
            b = 8'((w >> (8 * (3 - off))) & 32'hFF);
            h = 16'((w >> (16 * (1 - off / 2))) & 32'hFFFF);
            e_ld = 32'h0;
            ltag = "R7/R11 ld_data";
            if (dir == 0 && !bad) begin
                if (sz == 0) begin
                    e_ld = (sg == 1 && b[7]) ? (32'hFFFF_FF00 | 32'(b)) : 32'(b);
                    ltag = (sg == 1) ? "R8/R11 byte ld_data" : "R9/R11 byte ld_data";
                end else if (sz == 1) begin
                    e_ld = (sg == 1 && h[15]) ? (32'hFFFF_0000 | 32'(h)) : 32'(h);
                    ltag = (sg == 1) ? "R8/R11 half ld_data" : "R9/R11 half ld_data";
                end else e_ld = w;
            end else ltag = "R6 ld_data idle";
            #1;
            chk("R6 ld_valid", {31'b0, ld_valid}, {31'b0, (dir == 0 && !bad)});
            chk(ltag, ld_data, e_ld);
        end
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule